// File: doc/BRIEF.md
# Video Memory Host Access Port

This block sits between a host processor's byte-wide register interface and a 512 KB video RAM built from two physical banks. The host loads a 19-bit write pointer and a separate 19-bit read pointer, one byte at a time, then streams bytes through a data port. Each pointer can step by one after every data access, or stay put when its inhibit flag is set.

Reads go through a one-byte read-ahead latch. The data port always returns what the latch holds and then refills the latch from the read pointer. The latch is refilled only by a data read or by a load of the read pointer's high byte. After a change to only the low or middle byte, the next read therefore returns the byte fetched for the previous address.

Logical addresses are turned into physical ones by a display-mode input. In the linear mode the two are equal. In bitmap modes even and odd bytes are interleaved across the two banks. A memory-size input masks the physical address, so a small configuration shows the same byte at several logical addresses.

Top module: `vram_host_port`

## Requirements
- R1: After reset both pointers and both inhibit flags are zero, the read latch holds 0 so `dp_rdata` is 0, and `mem_we` and `mem_re` are low.
- R2: Register writes with `reg_sel` 0, 1 and 2 load write-pointer bits 7:0, bits 15:8 and bits 18:16 (from data bits 2:0). Bit 7 of the select-2 byte is the write inhibit flag. Any single byte may be rewritten alone, and the very next data write uses the combined pointer.
- R3: A data write (`dp_wr`) stores `dp_wdata` at the translated write pointer in that same cycle. The pointer then steps by one, wrapping from 0x7FFFF to 0, unless its inhibit flag is set.
- R4: Register writes with `reg_sel` 3 and 4 load read-pointer bits 7:0 and 15:8 and start no fetch. The first data read after such a write returns the byte fetched for the earlier pointer; the read after that returns the byte at the new pointer.
- R5: A register write with `reg_sel` 5 loads read-pointer bits 18:16 (data bits 2:0) and the read inhibit flag (data bit 7), and starts a fetch. The next data read returns the byte at the new address.
- R6: A data read (`dp_rd`) returns the latch contents in that same cycle. The read pointer then steps unless it is inhibited, `mem_re` is raised in the following cycle at the new address, and the latch takes the RAM byte two cycles after `mem_re`.
- R7: With `bitmap_mode` 0 (linear), the physical address equals the logical address before size masking.
- R8: With `bitmap_mode` 1, the physical address is {logical bit 0, logical bits 18:1}, so even bytes fall in bank 0 (0x00000–0x3FFFF) and odd bytes fall in bank 1 (0x40000–0x7FFFF).
- R9: `mem_size` 0 selects 128 KB, 1 selects 256 KB, and 2 or 3 select 512 KB. In linear mode the address keeps its low 17, 18 or 19 bits. In bitmap mode the bank bit is kept and the in-bank offset keeps 16, 17 or 18 bits.
- R10: When a data write and a pending fetch meet in the same cycle, the write uses the RAM port and `mem_re` stays low. The fetch is issued in the next free cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Pointer register write strobe |
| reg_sel | input | 3 | Pointer byte select, 0–5 |
| reg_wdata | input | 8 | Pointer byte value |
| dp_wr | input | 1 | Data port write strobe |
| dp_wdata | input | 8 | Data port write byte |
| dp_rd | input | 1 | Data port read strobe |
| dp_rdata | output | 8 | Read-ahead latch contents |
| bitmap_mode | input | 1 | 0 linear, 1 bank-interleaved |
| mem_size | input | 2 | Memory size code |
| mem_addr | output | 19 | Physical RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | 8 | RAM write byte |
| mem_re | output | 1 | RAM read enable, data valid one cycle later |
| mem_rdata | input | 8 | RAM read byte |

## Verification
The assertions assume a host that never strobes `dp_wr` and a register write of the same pointer in one cycle, and that never writes a pointer byte in the same cycle as a data access to that pointer. They also assume the RAM answers every `mem_re` with valid data exactly one cycle later. The bench keeps to these assumptions by issuing each register write and each data access as an isolated one-cycle pulse, followed by idle cycles long enough for any fetch to land in the latch. The one deliberate overlap is a data write placed right after a high-byte read-pointer load; it exercises the port-sharing rule.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

  localparam int VP_ADDR_W = 19;
  localparam int VP_DATA_W = 8;

  // Number of address bits kept for a size code.
  function automatic int kept_bits(input logic [1:0] sz, input int aw);
    case (sz)
      2'd0:    return aw - 2;
      2'd1:    return aw - 1;
      default: return aw;
    endcase
  endfunction

  function automatic logic [VP_ADDR_W-1:0] low_mask(input int bits);
    logic [VP_ADDR_W-1:0] m;
    m = '1;
    return m >> (VP_ADDR_W - bits);
  endfunction

  // Logical to physical: mode selects linear or bank interleave, size masks.
  function automatic logic [VP_ADDR_W-1:0] to_phys(input logic [VP_ADDR_W-1:0] la,
                                                   input logic bm,
                                                   input logic [1:0] sz);
    logic [VP_ADDR_W-1:0] off;
    int keep;
    keep = kept_bits(sz, VP_ADDR_W);
    if (!bm) begin
      return la & low_mask(keep);
    end
    off = (la >> 1) & low_mask(keep - 1);
    return {la[0], off[VP_ADDR_W-2:0]};
  endfunction

endpackage

// File: rtl/vram_ptr_regs.sv
module vram_ptr_regs #(
  parameter int ADDR_W = 19,
  parameter int SEL_BASE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [2:0]        sel,
  input  logic [7:0]        wdata,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr,
  output logic              inh,
  output logic              hi_load
);
  localparam int HI_W = ADDR_W - 16;
  localparam logic [2:0] SEL_LO  = 3'(SEL_BASE);
  localparam logic [2:0] SEL_MID = 3'(SEL_BASE + 1);
  localparam logic [2:0] SEL_HI  = 3'(SEL_BASE + 2);

  logic ld_lo, ld_mid, ld_hi;
  assign ld_lo   = ld && (sel == SEL_LO);
  assign ld_mid  = ld && (sel == SEL_MID);
  assign ld_hi   = ld && (sel == SEL_HI);
  assign hi_load = ld_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      inh <= 1'b0;
    end else if (ld_lo) begin
      ptr[7:0] <= wdata;
    end else if (ld_mid) begin
      ptr[15:8] <= wdata;
    end else if (ld_hi) begin
      ptr[ADDR_W-1:16] <= wdata[HI_W-1:0];
      inh              <= wdata[7];
    end else if (step && !inh) begin
      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/vram_fetch.sv
module vram_fetch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trigger,
  input  logic              port_busy,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_re,
  output logic              req,
  output logic [DATA_W-1:0] latch
);
  logic wait_q;

  assign mem_re = req && !port_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req    <= 1'b0;
      wait_q <= 1'b0;
      latch  <= '0;
    end else begin
      req    <= mem_re ? trigger : (req || trigger);
      wait_q <= mem_re;
      if (wait_q) latch <= mem_rdata;
    end
  end
endmodule

// File: rtl/vram_host_port.sv
module vram_host_port
  import vram_port_pkg::*;
#(
  parameter int ADDR_W = VP_ADDR_W,
  parameter int DATA_W = VP_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  input  logic              dp_wr,
  input  logic [DATA_W-1:0] dp_wdata,
  input  logic              dp_rd,
  output logic [DATA_W-1:0] dp_rdata,
  input  logic              bitmap_mode,
  input  logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [ADDR_W-1:0] wr_ptr, rd_ptr, wr_phys, rd_phys;
  logic              wr_inh, rd_inh, wr_hi_evt, rd_hi_evt;
  logic              fetch_req, fetch_trig;

  vram_ptr_regs #(.ADDR_W(ADDR_W), .SEL_BASE(0)) u_wptr (
    .clk(clk), .rst_n(rst_n), .ld(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .step(dp_wr), .ptr(wr_ptr), .inh(wr_inh), .hi_load(wr_hi_evt)
  );

  vram_ptr_regs #(.ADDR_W(ADDR_W), .SEL_BASE(3)) u_rptr (
    .clk(clk), .rst_n(rst_n), .ld(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .step(dp_rd), .ptr(rd_ptr), .inh(rd_inh), .hi_load(rd_hi_evt)
  );

  assign fetch_trig = dp_rd || rd_hi_evt;

  vram_fetch #(.DATA_W(DATA_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .trigger(fetch_trig), .port_busy(dp_wr),
    .mem_rdata(mem_rdata), .mem_re(mem_re), .req(fetch_req), .latch(dp_rdata)
  );

  assign wr_phys   = to_phys(wr_ptr, bitmap_mode, mem_size);
  assign rd_phys   = to_phys(rd_ptr, bitmap_mode, mem_size);
  assign mem_we    = dp_wr;
  assign mem_wdata = dp_wdata;
  assign mem_addr  = dp_wr ? wr_phys : rd_phys;
endmodule

// File: rtl/vram_host_port_chk.sv
module vram_host_port_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_sel,
  input logic              dp_wr,
  input logic              dp_rd,
  input logic [DATA_W-1:0] dp_rdata,
  input logic              bitmap_mode,
  input logic [1:0]        mem_size,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic              wr_inh,
  input logic              fetch_req
);
  p_port_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_hi_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 3'd5) |=> (mem_re || dp_wr));

  p_no_fetch_partial_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_sel == 3'd3 || reg_sel == 3'd4) && !fetch_req && !dp_rd) |=> !mem_re);

  p_latch_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_re, 2) |-> dp_rdata == $past(mem_rdata));

  p_wr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dp_wr && !wr_inh && !reg_we) |-> wr_ptr == $past(wr_ptr) + 1'b1);

  p_linear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !bitmap_mode && mem_size[1]) |-> mem_addr == wr_ptr);

  p_bank_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && bitmap_mode) |-> mem_addr[ADDR_W-1] == wr_ptr[0]);
endmodule

bind vram_host_port vram_host_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .dp_wr(dp_wr),
  .dp_rd(dp_rd), .dp_rdata(dp_rdata), .bitmap_mode(bitmap_mode), .mem_size(mem_size),
  .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
  .wr_ptr(wr_ptr), .wr_inh(wr_inh), .fetch_req(fetch_req)
);

// File: tb/test_vram_host_port.sv
module test_vram_host_port;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0, dp_wr = 0, dp_rd = 0, bitmap_mode = 0;
  logic [2:0]  reg_sel = 0;
  logic [7:0]  reg_wdata = 0, dp_wdata = 0, dp_rdata, mem_wdata, mem_rdata;
  logic [1:0]  mem_size = 2;
  logic [18:0] mem_addr;
  logic        mem_we, mem_re;
  int          n_run = 0, n_fail = 0, cyc = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  vram_host_port i_vram_host_port (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rd(dp_rd), .dp_rdata(dp_rdata),
    .bitmap_mode(bitmap_mode), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  // Synchronous RAM model, one cycle read latency.
  logic [7:0] ram [int];
  always @(posedge clk) begin
    if (mem_we) ram[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] s, input logic [7:0] v);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = v;
    @(negedge clk); reg_we = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_wptr(input logic [18:0] a, input logic inh);
    wreg(3'd0, a[7:0]); wreg(3'd1, a[15:8]); wreg(3'd2, {inh, 4'd0, a[18:16]});
  endtask

  task automatic set_rptr(input logic [18:0] a, input logic inh);
    wreg(3'd3, a[7:0]); wreg(3'd4, a[15:8]); wreg(3'd5, {inh, 4'd0, a[18:16]});
  endtask

  task automatic dwrite(input logic [7:0] v, output logic [18:0] at);
    @(negedge clk); dp_wr = 1; dp_wdata = v;
    #1 at = mem_addr;
    @(negedge clk); dp_wr = 0;
    @(negedge clk);
  endtask

  task automatic dread(output logic [7:0] v);
    @(negedge clk); dp_rd = 1;
    #1 v = dp_rdata;
    @(negedge clk); dp_rd = 0;
    repeat (3) @(negedge clk);
  endtask

  // {bitmap_mode, mem_size, logical, expected physical}
  typedef struct packed { logic bm; logic [1:0] sz; logic [18:0] la; logic [18:0] pa; } vec_t;
  localparam vec_t VECS [10] = '{
    '{1'b0, 2'd2, 19'h12345, 19'h12345},
    '{1'b0, 2'd2, 19'h7FFFF, 19'h7FFFF},
    '{1'b1, 2'd2, 19'h00002, 19'h00001},
    '{1'b1, 2'd2, 19'h00003, 19'h40001},
    '{1'b1, 2'd2, 19'h7FFFF, 19'h7FFFF},
    '{1'b0, 2'd0, 19'h6ABCD, 19'h0ABCD},
    '{1'b0, 2'd1, 19'h6ABCD, 19'h2ABCD},
    '{1'b1, 2'd0, 19'h6ABCD, 19'h455E6},
    '{1'b1, 2'd1, 19'h6ABCD, 19'h555E6},
    '{1'b1, 2'd3, 19'h6ABCC, 19'h355E6}
  };

  initial begin
    logic [18:0] a;
    logic [7:0]  v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 latch after reset", dp_rdata, 8'h00);
    chk("R1 mem_we after reset", mem_we, 1'b0);
    chk("R1 mem_re after reset", mem_re, 1'b0);

    // Address translation table: R7 linear, R8 interleave, R9 size masks
    foreach (VECS[i]) begin
      bitmap_mode = VECS[i].bm; mem_size = VECS[i].sz;
      set_wptr(VECS[i].la, 1'b1);
      dwrite(8'h11, a);
      chk($sformatf("R7/R8/R9 vector %0d", i), a, VECS[i].pa);
    end
    bitmap_mode = 0; mem_size = 2;

    // R2 partial write pointer rewrite, R3 inhibit
    wreg(3'd0, 8'h11); wreg(3'd1, 8'h22); wreg(3'd2, 8'h83);
    dwrite(8'h01, a); chk("R2 combined pointer", a, 19'h32211);
    wreg(3'd1, 8'h55);
    dwrite(8'h02, a); chk("R2 middle byte alone", a, 19'h35511);
    dwrite(8'h03, a); chk("R3 inhibited pointer holds", a, 19'h35511);

    // R3 step and wrap
    set_wptr(19'h7FFFF, 1'b0);
    dwrite(8'h04, a); chk("R3 top address", a, 19'h7FFFF);
    dwrite(8'h05, a); chk("R3 wrap to zero", a, 19'h00000);

    // Preload bytes for read tests
    set_wptr(19'h00000, 1'b0);
    dwrite(8'hA0, a); dwrite(8'hA1, a); dwrite(8'hA2, a);
    set_wptr(19'h00201, 1'b1); dwrite(8'hB1, a);
    set_wptr(19'h30201, 1'b1); dwrite(8'hC1, a);

    // R5 fetch on high byte, R4 stale first read
    set_rptr(19'h00000, 1'b1);
    dread(v); chk("R5 read after high byte load", v, 8'hA0);
    wreg(3'd3, 8'h01);
    dread(v); chk("R4 first read after low byte is stale", v, 8'hA0);
    dread(v); chk("R4 second read uses new low byte", v, 8'hA1);
    wreg(3'd4, 8'h02);
    dread(v); chk("R4 first read after middle byte is stale", v, 8'hA1);
    dread(v); chk("R4 second read uses new middle byte", v, 8'hB1);
    wreg(3'd5, 8'h83);
    dread(v); chk("R5 high byte refetches at once", v, 8'hC1);

    // R6 streaming reads with step
    set_rptr(19'h00000, 1'b0);
    dread(v); chk("R6 stream byte 0", v, 8'hA0);
    dread(v); chk("R6 stream byte 1", v, 8'hA1);
    dread(v); chk("R6 stream byte 2", v, 8'hA2);

    // R9 mirror in 128 KB linear mode
    mem_size = 0;
    set_rptr(19'h20001, 1'b1);
    dread(v); chk("R9 128KB mirror of byte 1", v, 8'hA1);
    mem_size = 2;

    // R10 write collides with pending fetch
    set_wptr(19'h00100, 1'b1);
    wreg(3'd3, 8'h00); wreg(3'd4, 8'h01);
    @(negedge clk); reg_we = 1; reg_sel = 3'd5; reg_wdata = 8'h80;
    @(negedge clk); reg_we = 0; dp_wr = 1; dp_wdata = 8'h5A;
    #1 chk("R10 write owns port", {mem_we, mem_re}, 2'b10);
    @(negedge clk); dp_wr = 0;
    #1 chk("R10 deferred fetch issued", mem_re, 1'b1);
    repeat (3) @(negedge clk);
    dread(v); chk("R10 fetch sees written byte", v, 8'h5A);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule